// File: doc/BRIEF.md
# Local Bus Transfer Error Monitor

This block sits beside the controller of a simple external memory bus and watches each transaction for six error conditions: a data beat that never arrives, a failed byte-lane parity check, a write into a read-only region, two atomic pairing time-outs (one for each order of the pair), and a transaction that selects no bank. Each condition sets its own sticky bit in a status register. The block also keeps a check-disable register, an interrupt-enable register, a bus time-out field and a capture of the first parity failure. All of these sit behind a small register port that is decoded without wait states. The interrupt output is the OR of the status bits that are enabled.

The bus controller drives a transaction-start pulse. With that pulse come the write flag, the bank-hit flag, the bank index and the read-only attribute of the hit bank. Each acknowledged data beat arrives as a pulse together with the per-lane parity check results. Atomic pairs are reported by an open pulse, which carries the order (read first or write first) and the bank, and a close pulse, which carries the bank of the completing access. Every interface here is a plain control or status pin. Nothing is streamed, so the block has no valid/ready handshake and never applies back-pressure.

Top module: `lbus_err_mon`

## Requirements
- R1: With time-out field F (F > 0) and a transaction started at clock edge E0, status bit 0 is set at edge E(8*F) if no beat_ack was sampled at edges E1 through E(8*F). A beat_ack at any of those edges prevents the error. A new start restarts the count.
- R2: With a time-out field of zero, the bus monitor never sets status bit 0.
- R3: A beat_ack with any par_err bit set sets status bit 1. Register 3 then holds the lowest failing lane in bits [LANE_W-1:0] and the bank of the current transaction in bits [8 +: BANK_W].
- R4: Register 3 is loaded only when the whole status register is zero, so the first capture is kept until software clears every status bit.
- R5: A started transaction with xact_write=1, xact_bank_hit=1 and xact_ro=1 sets status bit 2. A read to a read-only bank sets nothing.
- R6: An atom_open with atom_kind=0 (read first) at edge E0 sets status bit 3 at edge E(ATOM_WIN), unless an atom_close with a matching bank was sampled at one of the edges E1 through E(ATOM_WIN). A close that names a different bank is ignored.
- R7: The same window applies to atom_open with atom_kind=1 (write first), which sets status bit 4 instead.
- R8: A started transaction with xact_bank_hit=0 sets status bit 5 at the start edge. If no beat is acknowledged, the time-out of R1 follows.
- R9: Register 1 (check disable, bit positions as in status) stops the matching error from being recorded, whatever register 2 holds.
- R10: After reset, status, disable, enable and capture read as zero, register 4 reads TMO_RST, and irq is low.
- R11: Writing register 0 clears each status bit written as 1 and leaves the others. A new error in the same cycle wins over the clear. Status bits otherwise hold.
- R12: irq is high exactly when a status bit and the same bit of register 2 are both set. It follows register changes without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xact_start | input | 1 | Transaction start pulse |
| xact_write | input | 1 | Transaction is a write |
| xact_bank_hit | input | 1 | Address matched a configured bank |
| xact_bank | input | BANK_W | Index of the hit bank |
| xact_ro | input | 1 | Hit bank is read-only |
| beat_ack | input | 1 | Data beat acknowledged |
| par_err | input | LANES | Per-lane parity failure, qualified by beat_ack |
| atom_open | input | 1 | Start of an atomic pair |
| atom_kind | input | 1 | 0 = read first, 1 = write first |
| atom_bank | input | BANK_W | Bank of the opening access |
| atom_close | input | 1 | Completing access of an atomic pair |
| atom_close_bank | input | BANK_W | Bank of the completing access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 status, 1 disable, 2 enable, 3 capture, 4 time-out field |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
A counter that stops one cycle early or one cycle late moves the status bit across the final edge of its window. The bench sweeps the acknowledge and close delays through every position up to two cycles past the limit, so such a fault shows at the status port on the first run past the boundary. A wrong priority encoder or a lost bank latch shows in the capture register on the very next read. A disable or enable bit steering the wrong error shows as a status or irq difference within one cycle of the triggering event.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  localparam int ERR_N  = 6;
  localparam int E_TMO  = 0;
  localparam int E_PAR  = 1;
  localparam int E_WP   = 2;
  localparam int E_ATW  = 3;
  localparam int E_ATR  = 4;
  localparam int E_CS   = 5;
  localparam int REG_AW = 3;
  localparam int BANK_POS = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_STS  = 3'd0,
    RA_DIS  = 3'd1,
    RA_IEN  = 3'd2,
    RA_ATTR = 3'd3,
    RA_TMO  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/lbm_bus_timer.sv
module lbm_bus_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ack,
  input  logic [TMO_W-1:0] field,
  output logic             expire
);
  localparam int CW = TMO_W + 3;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          off;

  assign limit  = {field, 3'b000};
  assign off    = (field == '0);
  assign expire = busy && !start && !ack && !off && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (ack || off || expire) busy <= 1'b0;
      else                      cnt  <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/lbm_atomic_win.sv
module lbm_atomic_win #(
  parameter int ATOM_WIN = 256,
  parameter int BANK_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic              kind_i,
  input  logic [BANK_W-1:0] open_bank,
  input  logic              close_i,
  input  logic [BANK_W-1:0] close_bank,
  output logic              err_w,
  output logic              err_r
);
  localparam int CW = $clog2(ATOM_WIN + 1);

  logic              armed;
  logic              kind_q;
  logic [BANK_W-1:0] bank_q;
  logic [CW-1:0]     cnt;
  logic              hit;
  logic              last;

  assign hit   = close_i && (close_bank == bank_q);
  assign last  = armed && !hit && (cnt == CW'(ATOM_WIN - 1));
  assign err_w = last && !kind_q;
  assign err_r = last && kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      kind_q <= 1'b0;
      bank_q <= '0;
      cnt    <= '0;
    end else if (open_i) begin
      armed  <= 1'b1;
      kind_q <= kind_i;
      bank_q <= open_bank;
      cnt    <= '0;
    end else if (armed) begin
      if (hit || last) armed <= 1'b0;
      else             cnt   <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/lbm_regfile.sv
module lbm_regfile
  import lbm_pkg::*;
#(
  parameter int TMO_W   = 8,
  parameter int LANE_W  = 2,
  parameter int BANK_W  = 3,
  parameter int DATA_W  = 32,
  parameter int TMO_RST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ERR_N-1:0]  evt,
  input  logic              cap_req,
  input  logic [LANE_W-1:0] cap_lane,
  input  logic [BANK_W-1:0] cap_bank,
  output logic [ERR_N-1:0]  sts_q,
  output logic [ERR_N-1:0]  dis_q,
  output logic [ERR_N-1:0]  ien_q,
  output logic [TMO_W-1:0]  tmo_q,
  output logic [LANE_W-1:0] lane_q,
  output logic [BANK_W-1:0] bank_q,
  output logic              irq
);
  logic [ERR_N-1:0] w1c;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata;
  assign w1c = (reg_wr && reg_addr == RA_STS) ? reg_wdata[ERR_N-1:0] : '0;
  assign irq = |(sts_q & ien_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q  <= '0;
      dis_q  <= '0;
      ien_q  <= '0;
      tmo_q  <= TMO_W'(TMO_RST);
      lane_q <= '0;
      bank_q <= '0;
    end else begin
      sts_q <= (sts_q & ~w1c) | evt;
      if (cap_req && sts_q == '0) begin
        lane_q <= cap_lane;
        bank_q <= cap_bank;
      end
      if (reg_wr) begin
        case (reg_addr)
          RA_DIS:  dis_q <= reg_wdata[ERR_N-1:0];
          RA_IEN:  ien_q <= reg_wdata[ERR_N-1:0];
          RA_TMO:  tmo_q <= reg_wdata[TMO_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_STS:  reg_rdata[ERR_N-1:0] = sts_q;
      RA_DIS:  reg_rdata[ERR_N-1:0] = dis_q;
      RA_IEN:  reg_rdata[ERR_N-1:0] = ien_q;
      RA_TMO:  reg_rdata[TMO_W-1:0] = tmo_q;
      RA_ATTR: begin
        reg_rdata[LANE_W-1:0]        = lane_q;
        reg_rdata[BANK_POS +: BANK_W] = bank_q;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lbus_err_mon.sv
module lbus_err_mon
  import lbm_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int BANKS    = 8,
  parameter int TMO_W    = 8,
  parameter int TMO_RST  = 32,
  parameter int ATOM_WIN = 256,
  parameter int DATA_W   = 32,
  localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xact_start,
  input  logic              xact_write,
  input  logic              xact_bank_hit,
  input  logic [BANK_W-1:0] xact_bank,
  input  logic              xact_ro,
  input  logic              beat_ack,
  input  logic [LANES-1:0]  par_err,
  input  logic              atom_open,
  input  logic              atom_kind,
  input  logic [BANK_W-1:0] atom_bank,
  input  logic              atom_close,
  input  logic [BANK_W-1:0] atom_close_bank,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [ERR_N-1:0]  raw_evt;
  logic [ERR_N-1:0]  evt;
  logic [ERR_N-1:0]  sts_q, dis_q, ien_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [LANE_W-1:0] attr_lane;
  logic [BANK_W-1:0] attr_bank;
  logic [BANK_W-1:0] cur_bank;
  logic              tmo_hit, atw_hit, atr_hit;
  logic              par_hit;
  logic [LANE_W-1:0] fail_lane;

  function automatic logic [LANE_W-1:0] lowest_lane(input logic [LANES-1:0] v);
    lowest_lane = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (v[i]) lowest_lane = LANE_W'(i);
    end
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)          cur_bank <= '0;
    else if (xact_start) cur_bank <= xact_bank;
  end

  assign par_hit   = beat_ack && (par_err != '0);
  assign fail_lane = lowest_lane(par_err);

  lbm_bus_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (xact_start),
    .ack    (beat_ack),
    .field  (tmo_q),
    .expire (tmo_hit)
  );

  lbm_atomic_win #(.ATOM_WIN(ATOM_WIN), .BANK_W(BANK_W)) u_atomic (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_i     (atom_open),
    .kind_i     (atom_kind),
    .open_bank  (atom_bank),
    .close_i    (atom_close),
    .close_bank (atom_close_bank),
    .err_w      (atw_hit),
    .err_r      (atr_hit)
  );

  always_comb begin
    raw_evt        = '0;
    raw_evt[E_TMO] = tmo_hit;
    raw_evt[E_PAR] = par_hit;
    raw_evt[E_WP]  = xact_start && xact_write && xact_bank_hit && xact_ro;
    raw_evt[E_ATW] = atw_hit;
    raw_evt[E_ATR] = atr_hit;
    raw_evt[E_CS]  = xact_start && !xact_bank_hit;
  end

  assign evt = raw_evt & ~dis_q;

  lbm_regfile #(
    .TMO_W   (TMO_W),
    .LANE_W  (LANE_W),
    .BANK_W  (BANK_W),
    .DATA_W  (DATA_W),
    .TMO_RST (TMO_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt       (evt),
    .cap_req   (evt[E_PAR]),
    .cap_lane  (fail_lane),
    .cap_bank  (cur_bank),
    .sts_q     (sts_q),
    .dis_q     (dis_q),
    .ien_q     (ien_q),
    .tmo_q     (tmo_q),
    .lane_q    (attr_lane),
    .bank_q    (attr_bank),
    .irq       (irq)
  );
endmodule

// File: rtl/lbm_checker.sv
module lbm_checker
  import lbm_pkg::*;
#(
  parameter int TMO_W  = 8,
  parameter int LANE_W = 2,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xact_start,
  input logic              xact_write,
  input logic              xact_bank_hit,
  input logic              xact_ro,
  input logic              reg_wr,
  input logic              irq,
  input logic [ERR_N-1:0]  sts_q,
  input logic [ERR_N-1:0]  dis_q,
  input logic [ERR_N-1:0]  ien_q,
  input logic [TMO_W-1:0]  tmo_q,
  input logic [LANE_W-1:0] attr_lane,
  input logic [BANK_W-1:0] attr_bank
);
  assert_tmo_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q == '0 && !sts_q[E_TMO]) |=> !sts_q[E_TMO]);

  assert_attr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q != '0) |=> ($stable(attr_lane) && $stable(attr_bank)));

  assert_wp_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_start && xact_write && xact_bank_hit && xact_ro && !dis_q[E_WP]) |=> sts_q[E_WP]);

  assert_cs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_start && !xact_bank_hit && !dis_q[E_CS]) |=> sts_q[E_CS]);

  assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q[E_CS] && !sts_q[E_CS]) |=> !sts_q[E_CS]);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

bind lbus_err_mon lbm_checker #(
  .TMO_W  (TMO_W),
  .LANE_W (LANE_W),
  .BANK_W (BANK_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .xact_start    (xact_start),
  .xact_write    (xact_write),
  .xact_bank_hit (xact_bank_hit),
  .xact_ro       (xact_ro),
  .reg_wr        (reg_wr),
  .irq           (irq),
  .sts_q         (sts_q),
  .dis_q         (dis_q),
  .ien_q         (ien_q),
  .tmo_q         (tmo_q),
  .attr_lane     (attr_lane),
  .attr_bank     (attr_bank)
);

// File: tb/tb_lbus_err_mon.sv
module tb_lbus_err_mon;
  localparam int LANES = 4, BANKS = 4, TMO_W = 4, TMO_RST = 2, WIN = 8, DW = 32;
  localparam int BW = 2;

  logic clk = 0, rst_n = 0;
  logic xact_start = 0, xact_write = 0, xact_bank_hit = 0, xact_ro = 0;
  logic [BW-1:0] xact_bank = 0;
  logic beat_ack = 0;
  logic [LANES-1:0] par_err = 0;
  logic atom_open = 0, atom_kind = 0, atom_close = 0;
  logic [BW-1:0] atom_bank = 0, atom_close_bank = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0;
  logic [DW-1:0] reg_rdata;
  logic irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lbus_err_mon #(.LANES(LANES), .BANKS(BANKS), .TMO_W(TMO_W), .TMO_RST(TMO_RST),
                 .ATOM_WIN(WIN), .DATA_W(DW)) dut (.*);

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic xact(input logic w, input logic hit, input logic [BW-1:0] b, input logic ro);
    @(negedge clk); xact_start = 1; xact_write = w; xact_bank_hit = hit; xact_bank = b; xact_ro = ro;
    @(negedge clk); xact_start = 0;
  endtask

  task automatic ack_at(input int d, input logic [LANES-1:0] p);
    repeat (d - 1) @(negedge clk);
    beat_ack = 1; par_err = p;
    @(negedge clk); beat_ack = 0; par_err = 0;
  endtask

  task automatic atom(input logic k, input logic [BW-1:0] b, input int d, input logic [BW-1:0] cb);
    @(negedge clk); atom_open = 1; atom_kind = k; atom_bank = b;
    @(negedge clk); atom_open = 0;
    repeat (d - 1) @(negedge clk);
    atom_close = 1; atom_close_bank = cb;
    @(negedge clk); atom_close = 0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      report();
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset values
    rd(0, v); check("R10 status", v, 0);
    rd(1, v); check("R10 disable", v, 0);
    rd(2, v); check("R10 enable", v, 0);
    rd(3, v); check("R10 capture", v, 0);
    rd(4, v); check("R10 tmo field", v, TMO_RST);
    check("R10 irq", {31'b0, irq}, 0);

    // R1 sweep of ack delay for several fields
    for (int f = 1; f <= 3; f++) begin
      wr(4, f);
      for (int d = 1; d <= 8 * f + 2; d++) begin
        wr(0, 32'h3f);
        xact(0, 1, 0, 0);
        ack_at(d, 0);
        repeat (3) @(negedge clk);
        rd(0, v);
        check($sformatf("R1 f=%0d d=%0d", f, d), v, (d > 8 * f) ? 1 : 0);
      end
    end

    // R2 zero field disables time-out
    wr(4, 0); wr(0, 32'h3f);
    xact(0, 1, 0, 0);
    repeat (200) @(negedge clk);
    rd(0, v); check("R2 no timeout", v, 0);
    ack_at(1, 0);

    // R3 parity sweep
    wr(4, 3);
    for (int b = 0; b < BANKS; b++) begin
      for (int p = 1; p < (1 << LANES); p++) begin
        int ln = 0;
        for (int i = LANES - 1; i >= 0; i--) if (p[i]) ln = i;
        wr(0, 32'h3f);
        xact(0, 1, b[BW-1:0], 0);
        ack_at(1, p[LANES-1:0]);
        rd(0, v); check($sformatf("R3 sts b=%0d p=%0d", b, p), v, 2);
        rd(3, v); check($sformatf("R3 attr b=%0d p=%0d", b, p), v, (b << 8) | ln);
      end
    end

    // R4 capture held while status nonzero
    wr(0, 32'h3f);
    xact(0, 1, 1, 0); ack_at(1, 4'b0100);
    xact(0, 1, 3, 0); ack_at(1, 4'b0001);
    rd(3, v); check("R4 capture held", v, (1 << 8) | 2);
    wr(0, 32'h3f);
    xact(0, 1, 3, 0); ack_at(1, 4'b1000);
    rd(3, v); check("R4 capture after clear", v, (3 << 8) | 3);

    // R5 write protect
    wr(0, 32'h3f);
    xact(1, 1, 2, 1); ack_at(1, 0);
    rd(0, v); check("R5 write to ro", v, 4);
    wr(0, 32'h3f);
    xact(0, 1, 2, 1); ack_at(1, 0);
    rd(0, v); check("R5 read of ro", v, 0);

    // R6 / R7 atomic window sweep
    for (int k = 0; k < 2; k++) begin
      for (int d = 1; d <= WIN + 2; d++) begin
        wr(0, 32'h3f);
        atom(k[0], 1, d, 1);
        repeat (3) @(negedge clk);
        rd(0, v);
        check($sformatf("%s d=%0d", k ? "R7" : "R6", d), v, (d > WIN) ? (k ? 16 : 8) : 0);
      end
    end
    wr(0, 32'h3f);
    atom(0, 1, 2, 2);
    repeat (WIN + 2) @(negedge clk);
    rd(0, v); check("R6 wrong bank close", v, 8);

    // R8 chip-select miss then time-out
    wr(4, 1); wr(0, 32'h3f);
    xact(0, 0, 0, 0);
    rd(0, v); check("R8 cs miss", v, 32);
    repeat (10) @(negedge clk);
    rd(0, v); check("R8 cs plus timeout", v, 33);

    // R9 disable independent of enable
    wr(0, 32'h3f); wr(1, 32'h3f); wr(2, 32'h3f);
    xact(0, 0, 0, 0);
    xact(1, 1, 0, 1); ack_at(1, 4'b0010);
    atom(1, 0, WIN + 2, 0);
    repeat (12) @(negedge clk);
    rd(0, v); check("R9 all disabled status", v, 0);
    check("R9 all disabled irq", {31'b0, irq}, 0);
    wr(1, 0); wr(2, 0);
    xact(1, 1, 0, 1); ack_at(1, 0);
    rd(0, v); check("R9 enable off still records", v, 4);
    // R12 irq gating
    check("R12 irq off", {31'b0, irq}, 0);
    wr(2, 4); check("R12 irq on", {31'b0, irq}, 1);
    wr(2, 1); check("R12 other bit", {31'b0, irq}, 0);

    // R11 write-one-to-clear
    wr(4, 0);
    xact(0, 0, 0, 0);
    rd(0, v); check("R11 two bits", v, 36);
    wr(0, 4); rd(0, v); check("R11 clear one", v, 32);
    wr(0, 0); rd(0, v); check("R11 zero write", v, 32);
    @(negedge clk);
    reg_wr = 1; reg_addr = 0; reg_wdata = 4;
    xact_start = 1; xact_write = 1; xact_bank_hit = 1; xact_ro = 1;
    @(negedge clk); reg_wr = 0; xact_start = 0;
    rd(0, v); check("R11 set wins", v, 36);

    done = 1;
    report();
  end
endmodule